// File: doc/BRIEF.md
# Serial Control Register Port

This block is the slave side of a compact host control link. A host reaches a bank of eight byte-wide registers through one shared bidirectional data line, a shift clock that the host drives, three register-select lines and two active-low strobes: one for reading and one for writing. Every strobe, the shift clock, the select lines and the incoming data line pass through two-flop synchronisers into the block's own system clock. All edge detection takes place in that clock domain. Each host event therefore reaches the block about four system clocks after it happens on the pins. The host's shift clock half-period must be well above that latency.

A read begins when the read strobe falls. The block then drives the shared line with the selected register, least significant bit first, and steps to the next bit on each falling shift-clock edge. A write has two phases. The host first shifts a byte in on falling shift-clock edges. It then pulses the write strobe low, and the byte is stored into the selected register when that strobe rises. Register 7 is read-only and reports an external status byte. The seven writable registers drive a flat configuration output. The block has no data stream, so it has no valid/ready handshake. All of its pins are plain control or status signals.

Top module: `ser_ctl_port`

## Requirements
- R1: While the asynchronous active-low reset is held, and after it is released, the seven writable registers read zero and the data-line enable `sdio_oe` is low.
- R2: `sdio_oe` is high only while a read is in progress, meaning the read strobe has fallen and is still low. It drops within a few system clocks after the strobe returns high. With the strobe high, the line is released.
- R3: On the falling edge of the read strobe, the register selected by `addr_i` is captured, and its bit 0 appears on `sdio_o`.
- R4: During a read, each falling edge of the shift clock advances the output by one bit. After n falling edges (n from 0 to 7), `sdio_o` carries bit n of the captured register.
- R5: While no read is in progress, each falling edge of the shift clock samples `sdio_i` into the top of an 8-bit shift register that moves towards bit 0. If more than eight bits are shifted, only the last eight are kept, and the first of those lands in bit 0.
- R6: On a rising edge of the write strobe, the shift register is stored into register `addr_i` (0 to 6), which appears at `cfg_o[8*addr_i+7 : 8*addr_i]`. No other register changes.
- R7: Register 7 is read-only. A read of it returns `status_i` as it was at the read strobe's falling edge, and a write to it changes no register.
- R8: A read does not alter any register.
- R9: Asserting reset during a read releases the data line at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host shift clock; data moves on its falling edge |
| rd_n_i | input | 1 | Active-low read strobe; frames a read and turns the data line around |
| wr_n_i | input | 1 | Active-low write strobe; commit on its rising edge |
| addr_i | input | 3 | Register select; must stay valid through the whole operation |
| sdio_i | input | 1 | Data line as seen from the pin (write data) |
| sdio_o | output | 1 | Data driven onto the line during a read |
| sdio_oe | output | 1 | High when the block drives the data line |
| status_i | input | 8 | Status byte returned by register 7 |
| cfg_o | output | 56 | Writable registers 0 to 6, register i in bits 8i+7 to 8i |

## Verification
The assertions check four properties on every cycle. The line is never driven once the synchronised read strobe has been high for a cycle. The configuration output holds still unless a write strobe has risen, and a write aimed at register 7 leaves it unchanged. The first output bit after a read start equals bit 0 of the selected register. In write shifting, the newest sampled bit enters the top of the shift register, and the bit counter never exceeds eight. Some behaviours show only in whole host transactions, through the bench's scenarios: that the least significant bit comes first across a full byte, that over-long shifts keep only the last eight bits, that status is captured at read start, that reads leave the registers unchanged, and that the line is released asynchronously when reset is asserted mid-read.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  localparam int unsigned WORD_W = 8;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned ADDR_W = $clog2(NUM_REGS);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam int unsigned NUM_RW = NUM_REGS - 1;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ser_ctl_sync.sv
module ser_ctl_sync #(
  parameter int unsigned N = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic [N-1:0] q_prev
);
  logic [N-1:0] s1, s2, s3;

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[b] <= RST_VAL[b];
        s2[b] <= RST_VAL[b];
        s3[b] <= RST_VAL[b];
      end else begin
        s1[b] <= d[b];
        s2[b] <= s1[b];
        s3[b] <= s2[b];
      end
    end
  end

  assign q = s2;
  assign q_prev = s3;
endmodule

// File: rtl/ser_ctl_shift.sv
module ser_ctl_shift
  import ser_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_fall,
  input  logic  rd_fall,
  input  logic  rd_high,
  input  logic  din,
  input  word_t load_val,
  output word_t sh_q,
  output logic  rd_active
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      rd_active <= 1'b0;
    end else if (rd_fall) begin
      sh_q      <= load_val;
      cnt_q     <= '0;
      rd_active <= 1'b1;
    end else if (rd_active) begin
      if (rd_high) begin
        rd_active <= 1'b0;
      end else if (sclk_fall && cnt_q < CNT_W'(WORD_W)) begin
        sh_q  <= {1'b0, sh_q[WORD_W-1:1]};
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (sclk_fall) begin
      sh_q <= {din, sh_q[WORD_W-1:1]};
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W));

  // R5
  shift_in_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && !rd_active && !rd_fall) |=> sh_q[WORD_W-1] == $past(din));
endmodule

// File: rtl/ser_ctl_bank.sv
module ser_ctl_bank
  import ser_ctl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  word_t                    wdata,
  input  logic [ADDR_W-1:0]        raddr,
  input  word_t                    status,
  output word_t                    rdata,
  output logic [NUM_RW*WORD_W-1:0] cfg
);
  localparam logic [ADDR_W-1:0] RO_IDX = ADDR_W'(NUM_REGS - 1);
  word_t regs [NUM_RW];

  for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[i] <= '0;
      else if (we && waddr == ADDR_W'(i)) regs[i] <= wdata;
    end
    assign cfg[i*WORD_W +: WORD_W] = regs[i];
  end

  always_comb begin
    rdata = status;
    for (int i = 0; i < NUM_RW; i++) begin
      if (raddr == ADDR_W'(i)) rdata = regs[i];
    end
  end

  // R7
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == RO_IDX) |=> $stable(cfg));
endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
  import ser_ctl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_i,
  input  logic                     rd_n_i,
  input  logic                     wr_n_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     sdio_i,
  output logic                     sdio_o,
  output logic                     sdio_oe,
  input  logic [WORD_W-1:0]        status_i,
  output logic [NUM_RW*WORD_W-1:0] cfg_o
);
  localparam int unsigned SYNC_W = 4 + ADDR_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(3'b110);

  logic [SYNC_W-1:0] s_now, s_prev;
  logic sclk_s, rd_s, wr_s, din_s;
  logic sclk_p, rd_p, wr_p;
  logic [ADDR_W-1:0] addr_s;
  logic sclk_fall, rd_fall, wr_rise;
  word_t sh_q, rd_word;
  logic rd_active;

  ser_ctl_sync #(.N(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sdio_i, addr_i, wr_n_i, rd_n_i, sclk_i}),
    .q(s_now), .q_prev(s_prev)
  );

  assign sclk_s = s_now[0];
  assign rd_s   = s_now[1];
  assign wr_s   = s_now[2];
  assign addr_s = s_now[3 +: ADDR_W];
  assign din_s  = s_now[SYNC_W-1];
  assign sclk_p = s_prev[0];
  assign rd_p   = s_prev[1];
  assign wr_p   = s_prev[2];

  assign sclk_fall = sclk_p & ~sclk_s;
  assign rd_fall   = rd_p & ~rd_s;
  assign wr_rise   = ~wr_p & wr_s & ~rd_active;

  ser_ctl_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_fall(sclk_fall), .rd_fall(rd_fall), .rd_high(rd_s),
    .din(din_s), .load_val(rd_word),
    .sh_q(sh_q), .rd_active(rd_active)
  );

  ser_ctl_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .we(wr_rise), .waddr(addr_s), .wdata(sh_q),
    .raddr(addr_s), .status(status_i),
    .rdata(rd_word), .cfg(cfg_o)
  );

  assign sdio_oe = rd_active;
  assign sdio_o  = rd_active & sh_q[0];

  // R2
  release_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_s) |-> !sdio_oe);

  // R3
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fall |=> sdio_o == $past(rd_word[0]));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rise |=> $stable(cfg_o));
endmodule

// File: tb/ser_ctl_port_test.sv
module ser_ctl_port_test;
  logic clk = 0, rst_n = 0, sclk = 0, rd_n = 1, wr_n = 1, sdi = 0;
  logic [2:0] addr = 0;
  logic [7:0] status = 8'hA5;
  logic sdo, oe;
  logic [55:0] cfg;
  int checks = 0, errors = 0;
  logic [7:0] model [7];
  logic [7:0] exp_q [$], got_q [$];
  string req_q [$];

  always #2.5 clk = ~clk;

  ser_ctl_port uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .addr_i(addr), .sdio_i(sdi), .sdio_o(sdo), .sdio_oe(oe),
    .status_i(status), .cfg_o(cfg)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [55:0] model_flat();
    logic [55:0] f;
    for (int i = 0; i < 7; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  // driver: pushes the expected byte, then shifts the read out
  task automatic read_reg(input logic [2:0] a, input string req);
    logic [7:0] got;
    exp_q.push_back(a == 3'd7 ? status : model[a]);
    req_q.push_back(req);
    addr = a;
    wt(2);
    rd_n = 0;
    wt(8);
    chk(oe == 1'b1, "R2 oe during read", 64'(oe), 64'd1);
    for (int b = 0; b < 8; b++) begin
      sclk = 1;              // host samples here: bit b (R4)
      got[b] = sdo;
      wt(8);
      sclk = 0;
      wt(8);
    end
    rd_n = 1;
    wt(8);
    chk(oe == 1'b0, "R2 released after read", 64'(oe), 64'd0);
    got_q.push_back(got);
  endtask

  task automatic shift_bits(input logic [15:0] bits, input int n);
    for (int b = 0; b < n; b++) begin
      sdi = bits[b];
      wt(4);
      sclk = 1;
      wt(8);
      sclk = 0;
      wt(8);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
    addr = a;
    shift_bits({8'h00, d}, 8);
    wr_n = 0;
    wt(8);
    wr_n = 1;
    wt(10);
    if (a != 3'd7) model[a] = d;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        string r;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(g == e, r, 64'(g), 64'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) model[i] = 8'h00;
    wt(3);
    // R1: state while in reset
    chk(oe == 1'b0, "R1 oe in reset", 64'(oe), 64'd0);
    chk(cfg == 56'd0, "R1 cfg in reset", 64'(cfg), 64'd0);
    rst_n = 1;
    wt(6);
    for (int i = 0; i < 7; i++) read_reg(3'(i), "R1 reset readback");
    read_reg(3'd7, "R7 status read");

    // R6 / R3 / R4: writes of distinct patterns then readback
    write_reg(3'd0, 8'h01);
    chk(cfg == model_flat(), "R6 cfg after write 0", 64'(cfg), 64'(model_flat()));
    write_reg(3'd3, 8'h80);
    write_reg(3'd6, 8'h5C);
    chk(cfg == model_flat(), "R6 cfg only addressed reg", 64'(cfg), 64'(model_flat()));
    write_reg(3'd1, 8'hFF);
    write_reg(3'd2, 8'h96);
    read_reg(3'd0, "R3 lsb first 01");
    read_reg(3'd3, "R4 msb only 80");
    read_reg(3'd6, "R4 pattern 5C");
    read_reg(3'd1, "R4 all ones");
    read_reg(3'd2, "R4 pattern 96");

    // R8: reads left registers alone
    chk(cfg == model_flat(), "R8 cfg after reads", 64'(cfg), 64'(model_flat()));

    // R5: twelve bits shifted, last eight kept
    addr = 3'd4;
    shift_bits(16'h0C3A, 12);
    wr_n = 0; wt(8); wr_n = 1; wt(10);
    model[4] = 8'hC3;
    chk(cfg[39:32] == 8'hC3, "R5 last eight bits kept", 64'(cfg[39:32]), 64'hC3);
    read_reg(3'd4, "R5 readback");

    // R7: write to read-only register ignored, status tracked
    write_reg(3'd7, 8'h3E);
    chk(cfg == model_flat(), "R7 write to status ignored", 64'(cfg), 64'(model_flat()));
    status = 8'h4B;
    read_reg(3'd7, "R7 new status");

    // R9: reset mid-read releases the line without a clock
    addr = 3'd1;
    wt(2);
    rd_n = 0;
    wt(10);
    chk(oe == 1'b1, "R9 driving before reset", 64'(oe), 64'd1);
    @(posedge clk);
    #1;
    rst_n = 0;
    rd_n = 1;
    #0.5;
    chk(oe == 1'b0, "R9 async release", 64'(oe), 64'd0);
    chk(cfg == 56'd0, "R1 reset clears regs", 64'(cfg), 64'd0);
    wt(3);
    rst_n = 1;
    for (int i = 0; i < 7; i++) model[i] = 8'h00;
    wt(6);
    read_reg(3'd1, "R1 readback after reset");

    wt(4);
    chk(exp_q.size() == 0, "scoreboard drained", 64'(exp_q.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule